// File: doc/BRIEF.md
# Slope-Compensated Reference Ramp and Trip Latch

This block sets the reference for a peak-current comparator that needs slope compensation. At the start of each switching cycle a sync pulse loads a reference code from the outer control loop. The code then falls by a programmed slope on every clock and stops at zero rather than wrapping. The code drives a 12-bit high-side DAC, which lies outside this block.

The analog comparator's decision comes back as a single raw bit. A sliding-window majority filter removes switching noise from it. The first filtered trip in a cycle sets a trip flag, which stays set until the next sync pulse. The PWM generator uses this flag to end the active phase.

The starting level and slope inputs may change at any time. They take effect only at a sync pulse. The filter window length and agreement threshold are parameters: `FILT_LEN` ranges from 1 to 32, and `FILT_THR` must exceed half of `FILT_LEN`.

Top module: `slope_trip_latch`

## Requirements
- R1: While reset is asserted and after its release, with no sync pulse yet, `dac_o` is 0 and `trip_o` is 0.
- R2: One clock after a clock edge with `sync_i` high, `dac_o` equals the `init_i` value present at that edge.
- R3: On each clock without sync, `dac_o` falls by the slope captured at the last sync pulse.
- R4: When the captured slope exceeds the current code, the next code is 0 and not a wrapped value. The code stays at 0 until the next sync pulse.
- R5: Changes to `init_i` and `slope_i` between sync pulses have no effect on `dac_o` until the next sync pulse.
- R6: The filter samples the raw bit every clock into an `FILT_LEN`-sample window. It asserts when at least `FILT_THR` samples are 1, and releases when at most `FILT_LEN-FILT_THR` samples are 1. Take a raw bit that goes high from an all-low history and stays high for w clocks. If w < `FILT_THR`, it never sets `trip_o`. Otherwise `trip_o` rises on the (`FILT_THR`+2)-th edge after the first high sample.
- R7: Once set, `trip_o` stays high regardless of the raw bit until a sync pulse.
- R8: A sync pulse clears `trip_o` on the next clock, even when a filtered trip is present on the same clock. If the filtered trip is still active, `trip_o` sets again on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Cycle-start pulse: loads ramp, clears trip |
| init_i | input | 12 | Ramp starting code from the control loop |
| slope_i | input | 12 | Amount subtracted from the ramp per clock |
| cmp_raw_i | input | 1 | Raw comparator decision, 1 = current above reference |
| dac_o | output | 12 | Reference code for the DAC |
| trip_o | output | 1 | Latched filtered trip flag |

## Verification
The assertions assume that `sync_i` is a single-clock pulse, sampled synchronously, and that `cmp_raw_i` is already synchronous to the clock. The stimulus drives every input on the falling edge and holds `sync_i` high for exactly one clock. It spaces sync pulses far enough apart that each ramp runs for many cycles. Before each trip test it holds the raw bit low for longer than the filter window, so the filter always starts from the all-low history that R6 describes.

// File: rtl/slope_trip_pkg.sv
package slope_trip_pkg;
  localparam int unsigned CODE_W = 12;
  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t sat_sub(code_t a, code_t b);
    return (b > a) ? '0 : code_t'(a - b);
  endfunction
endpackage

// File: rtl/ramp_gen.sv
module ramp_gen
  import slope_trip_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sync_i,
  input  code_t init_i,
  input  code_t slope_i,
  output code_t ramp_o
);
  code_t ramp_q, slope_q;

  // slope is shadowed; init is only sampled on the sync edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q  <= '0;
      slope_q <= '0;
    end else if (sync_i) begin
      ramp_q  <= init_i;
      slope_q <= slope_i;
    end else begin
      ramp_q  <= sat_sub(ramp_q, slope_q);
    end
  end

  assign ramp_o = ramp_q;

  p_sync_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> ramp_q == $past(init_i));
  p_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> ramp_q <= $past(ramp_q));
  p_no_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && ramp_q < slope_q) |=> ramp_q == '0);
  p_shadow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(slope_q));
endmodule

// File: rtl/trip_filter.sv
module trip_filter #(
  parameter int unsigned FILT_LEN = 8,
  parameter int unsigned FILT_THR = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);
  localparam int unsigned LOW_LIM = FILT_LEN - FILT_THR;

  logic [FILT_LEN-1:0] hist_q, hist_d;
  logic [CNT_W-1:0]    ones;
  logic                filt_q;

  generate
    if (FILT_LEN == 1) begin : g_one
      assign hist_d = raw_i;
    end else begin : g_many
      assign hist_d = {hist_q[FILT_LEN-2:0], raw_i};
    end
  endgenerate

  always_comb begin
    ones = '0;
    for (int i = 0; i < FILT_LEN; i++) ones = ones + CNT_W'(hist_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      if (ones >= CNT_W'(FILT_THR))     filt_q <= 1'b1;
      else if (ones <= CNT_W'(LOW_LIM)) filt_q <= 1'b0;
    end
  end

  assign filt_o = filt_q;

  initial begin
    a_cfg_r6: assert (FILT_LEN >= 1 && FILT_LEN <= 32 && 2 * FILT_THR > FILT_LEN
                      && FILT_THR <= FILT_LEN);
  end
endmodule

// File: rtl/trip_latch.sv
module trip_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic filt_i,
  output logic trip_o
);
  logic trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     trip_q <= 1'b0;
    else if (sync_i) trip_q <= 1'b0;   // clear wins over same-clock trip
    else if (filt_i) trip_q <= 1'b1;
  end

  assign trip_o = trip_q;

  p_only_filtered_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trip_q && !filt_i) |=> !trip_q);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_q && !sync_i) |=> trip_q);
  p_sync_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !trip_q);
endmodule

// File: rtl/slope_trip_latch.sv
module slope_trip_latch
  import slope_trip_pkg::*;
#(
  parameter int unsigned FILT_LEN = 8,
  parameter int unsigned FILT_THR = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [CODE_W-1:0] init_i,
  input  logic [CODE_W-1:0] slope_i,
  input  logic              cmp_raw_i,
  output logic [CODE_W-1:0] dac_o,
  output logic              trip_o
);
  logic filt;

  ramp_gen u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .init_i (init_i),
    .slope_i(slope_i),
    .ramp_o (dac_o)
  );

  trip_filter #(.FILT_LEN(FILT_LEN), .FILT_THR(FILT_THR)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (cmp_raw_i),
    .filt_o(filt)
  );

  trip_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_i),
    .filt_i(filt),
    .trip_o(trip_o)
  );
endmodule

// File: tb/slope_trip_latch_tb.sv
module slope_trip_latch_tb;
  localparam int FL = 8;
  localparam int FT = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_i = 1'b0;
  logic [11:0] init_i = '0;
  logic [11:0] slope_i = '0;
  logic        cmp_raw_i = 1'b0;
  logic [11:0] dac_o;
  logic        trip_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slope_trip_latch #(.FILT_LEN(FL), .FILT_THR(FT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .init_i(init_i),
    .slope_i(slope_i), .cmp_raw_i(cmp_raw_i), .dac_o(dac_o), .trip_o(trip_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_sync();
    sync_i = 1'b1;
    step();
    sync_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int inits[5]  = '{0, 5, 100, 2000, 4095};
    int slopes[5] = '{0, 1, 3, 250, 4095};

    step();
    chk("R1 dac in reset", dac_o, 0);
    chk("R1 trip in reset", trip_o, 0);
    rst_ni = 1'b1;
    step();
    step();
    chk("R1 dac after reset", dac_o, 0);
    chk("R1 trip after reset", trip_o, 0);

    // ramp sweep
    for (int a = 0; a < 5; a++) begin
      for (int b = 0; b < 5; b++) begin
        init_i  = 12'(inits[a]);
        slope_i = 12'(slopes[b]);
        pulse_sync();
        chk("R2 load", dac_o, inits[a]);
        // mid-cycle changes must not affect the running ramp
        init_i  = 12'hABC;
        slope_i = 12'd1;
        for (int k = 1; k <= 12; k++) begin
          int e;
          step();
          e = inits[a] - k * slopes[b];
          if (e < 0) e = 0;
          if (k == 6) begin
            init_i  = 12'h123;
            slope_i = 12'd2000;
          end
          if (e == 0) chk("R4 saturate", dac_o, e);
          else        chk("R3/R5 decrement", dac_o, e);
        end
      end
    end
    // pending shadow values apply at next sync
    init_i  = 12'd50;
    slope_i = 12'd7;
    pulse_sync();
    chk("R5 new init applied", dac_o, 50);
    step();
    chk("R5 new slope applied", dac_o, 43);

    // filter width sweep
    for (int w = 1; w <= FL + 2; w++) begin
      cmp_raw_i = 1'b0;
      repeat (FL + 2) step();
      pulse_sync();
      chk("R8 cleared before pulse", trip_o, 0);
      cmp_raw_i = 1'b1;
      for (int j = 1; j <= w + FL + 4; j++) begin
        int e;
        step();
        if (j == w) cmp_raw_i = 1'b0;
        e = (w >= FT && j >= FT + 2) ? 1 : 0;
        if (j > FT + 2 && e == 1) chk("R7 holds", trip_o, e);
        else                      chk("R6 filter timing", trip_o, e);
      end
    end

    // latched flag ignores raw toggling
    for (int j = 0; j < 20; j++) begin
      cmp_raw_i = j[0];
      step();
      chk("R7 toggle ignored", trip_o, 1);
    end

    // sync clear with same-clock active filtered trip
    cmp_raw_i = 1'b1;
    repeat (FL + 2) step();
    chk("R6 tripped", trip_o, 1);
    pulse_sync();
    chk("R8 clear priority", trip_o, 0);
    step();
    chk("R8 re-trip next cycle", trip_o, 1);

    // sync clear with quiet raw: stays clear
    cmp_raw_i = 1'b0;
    repeat (FL + 2) step();
    pulse_sync();
    chk("R8 cleared", trip_o, 0);
    repeat (5) step();
    chk("R8 stays clear", trip_o, 0);

    finish_run();
  end
endmodule